// File: doc/BRIEF.md
# Swap-Tolerant Two-Wire Bit Link

This block carries one serial data bit per clock over a pair of wires. The sending half takes a bit every cycle and updates two line outputs. The receiving half watches the two line inputs and reproduces the bit stream after a fixed latency. The latency is fixed when the block is built and may be one, two or three cycles. Both halves run on the same clock. They share no other signal, and each holds only a few bits of state.

The wiring between the two halves may be crossed, and either wire may be inverted. The wiring stays in whatever arrangement it has for the whole run. The receiver is never told which arrangement is in use. A 1 toggles both lines and a 0 toggles exactly one line, so the information sits in how many lines changed, and that count is the same in every wiring arrangement. In a cycle where neither line changes, the receiver outputs a 0 and raises a sticky error flag.

Top module: `twowire_link`

## Requirements
- R1: `data_o` equals the `data_i` value sampled `LAT` rising edges earlier, once `valid_o` is high; `LAT` is a parameter in the range 1 to 3 (default 2).
- R2: From the second edge after reset release onward, at least one of `line_a_o` and `line_b_o` differs from its value in the previous cycle, in every cycle.
- R3: On each edge, a sampled 1 inverts both line outputs. A sampled 0 inverts exactly one line output. Starting from reset, the first 0 inverts line A, the next 0 inverts line B, and so on alternately.
- R4: Decoding is correct for all eight wiring arrangements: straight or crossed, each combined with no inversion, inversion of either wire alone, or inversion of both.
- R5: While `rst_i` is high, both line outputs, `data_o`, `valid_o` and `err_o` are 0. Whenever `valid_o` is low, `data_o` is 0.
- R6: `valid_o` goes high exactly `LAT` edges after the first edge at which `rst_i` is low, and stays high until the next reset.
- R7: A cycle in which neither received line changes is decoded as 0. In that case, `err_o` rises on the next edge.
- R8: `err_o` stays high until `rst_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | 1 | Serial bit to send, sampled every edge |
| line_a_o | output | 1 | Transmit wire A |
| line_b_o | output | 1 | Transmit wire B |
| line_a_i | input | 1 | Received wire, first of the pair |
| line_b_i | input | 1 | Received wire, second of the pair |
| data_o | output | 1 | Recovered bit |
| valid_o | output | 1 | Recovered bit is meaningful |
| err_o | output | 1 | Sticky flag: a cycle with no line change was seen |

## Verification
The assertions check the following on every cycle: the transmitter never holds both lines still, an idle received cycle always raises the error flag, that flag never drops outside reset, and no data shows before the valid signal. Three things only the bench scenarios can show. The first is that the recovered stream matches the sent stream at the right latency in all eight wiring arrangements. The second is the exact alternation of the single-line toggles. The third is that an injected frozen cycle yields a 0 on the data output at the matching position.

// File: rtl/twowire_link.sv
module twowire_link #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic data_i,
  output logic line_a_o,
  output logic line_b_o,
  input  logic line_a_i,
  input  logic line_b_i,
  output logic data_o,
  output logic valid_o,
  output logic err_o
);

  localparam int STG = (LAT > 1) ? LAT - 1 : 1;

  logic ta_q, tb_q, alt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ta_q  <= 1'b0;
      tb_q  <= 1'b0;
      alt_q <= 1'b0;
    end else if (data_i) begin
      ta_q <= ~ta_q;
      tb_q <= ~tb_q;
    end else begin
      if (alt_q) tb_q <= ~tb_q;
      else       ta_q <= ~ta_q;
      alt_q <= ~alt_q;
    end
  end

  assign line_a_o = ta_q;
  assign line_b_o = tb_q;

  logic pa_q, pb_q, hist_q, err_q;
  logic tog_a, tog_b, raw_bit, gap;

  assign tog_a   = line_a_i ^ pa_q;
  assign tog_b   = line_b_i ^ pb_q;
  assign raw_bit = hist_q & tog_a & tog_b;
  assign gap     = hist_q & ~tog_a & ~tog_b;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      hist_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pa_q   <= line_a_i;
      pb_q   <= line_b_i;
      hist_q <= 1'b1;
      if (gap) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  generate
    if (LAT <= 1) begin : g_direct
      assign data_o  = raw_bit;
      assign valid_o = hist_q;
    end else begin : g_pipe
      logic [STG-1:0] dsh_q, vsh_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          dsh_q <= '0;
          vsh_q <= '0;
        end else begin
          dsh_q[0] <= raw_bit;
          vsh_q[0] <= hist_q;
          for (int i = 1; i < STG; i++) begin
            dsh_q[i] <= dsh_q[i-1];
            vsh_q[i] <= vsh_q[i-1];
          end
        end
      end
      assign data_o  = dsh_q[STG-1];
      assign valid_o = vsh_q[STG-1];
    end
  endgenerate

  AST_LINE_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    hist_q |-> ({line_a_o, line_b_o} != $past({line_a_o, line_b_o}))); // R2
  AST_ERR_ON_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && !(line_a_i ^ pa_q) && !(line_b_i ^ pb_q)) |=> err_o); // R7
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o); // R8
  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    !hist_q |-> !valid_o); // R6
  AST_QUIET_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> !data_o); // R5

endmodule

// File: tb/twowire_link_tb.sv
module twowire_link_tb_top;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic la_o, lb_o, rxa, rxb, dout, vld, err;
  logic [2:0] chan = 3'd0;
  logic freeze_req = 1'b0, freeze_q = 1'b0;
  logic ha_q = 1'b0, hb_q = 1'b0;
  logic ca, cb;

  int compared = 0, mismatched = 0;
  int n = 0;
  int stop_idx = 1 << 30;
  int err_at = 1 << 30;
  bit hist[0:4095];
  bit ma, mb, malt;

  always #4 clk = ~clk;

  assign ca  = (chan[0] ? lb_o : la_o) ^ chan[1];
  assign cb  = (chan[0] ? la_o : lb_o) ^ chan[2];
  assign rxa = freeze_q ? ha_q : ca;
  assign rxb = freeze_q ? hb_q : cb;

  always @(posedge clk) begin
    ha_q     <= ca;
    hb_q     <= cb;
    freeze_q <= freeze_req;
  end

  twowire_link #(.LAT(LAT)) dut_i (
    .clk_i(clk), .rst_i(rst), .data_i(din),
    .line_a_o(la_o), .line_b_o(lb_o),
    .line_a_i(rxa), .line_b_i(rxb),
    .data_o(dout), .valid_o(vld), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (chan %0d, n %0d)", req, act, exp, chan, n);
    end
  endtask

  task automatic do_reset(input logic [2:0] c);
    rst = 1'b1;
    chan = c;
    freeze_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({la_o, lb_o, dout, vld, err} == 5'b0, "R5", {la_o, lb_o, dout, vld, err}, 0);
    rst = 1'b0;
    n = 0;
    ma = 0; mb = 0; malt = 0;
    stop_idx = 1 << 30;
    err_at = 1 << 30;
  endtask

  task automatic step(input bit d, input bit fz);
    bit pa, pb;
    din = d;
    freeze_req = fz;
    hist[n] = fz ? 1'b0 : d;
    if (fz) begin
      stop_idx = n + 1;
      err_at = n + 2;
    end
    pa = ma; pb = mb;
    if (d) begin ma = ~ma; mb = ~mb; end
    else begin
      if (malt) mb = ~mb; else ma = ~ma;
      malt = ~malt;
    end
    @(posedge clk);
    n++;
    @(negedge clk);
    chk(la_o == ma && lb_o == mb, "R3", {la_o, lb_o}, {ma, mb});
    chk({la_o, lb_o} != {pa, pb}, "R2", {la_o, lb_o}, {pa, pb});
    chk(vld == (n >= LAT), "R6", vld, n >= LAT);
    if (n >= LAT && (n - LAT) < stop_idx)
      chk(dout == hist[n - LAT], (stop_idx == n - LAT + 1) ? "R7" : "R1/R4",
          dout, hist[n - LAT]);
    if (!vld) chk(dout == 1'b0, "R5", dout, 0);
    chk(err == (n >= err_at), (n >= err_at) ? "R8" : "R7", err, n >= err_at);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      do_reset(s[2:0]);
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) step(i[0], 1'b0);
      for (int i = 0; i < 200; i++) step(1'($urandom), 1'b0);
    end
    for (int s = 2; s < 8; s += 3) begin
      do_reset(s[2:0]);
      for (int i = 0; i < 10; i++) step(1'($urandom), 1'b0);
      step(1'b1, 1'b1);
      for (int i = 0; i < 20; i++) step(1'($urandom), 1'b0);
    end
    do_reset(3'd0);
    for (int i = 0; i < 6; i++) step(1'($urandom), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule